// File: doc/BRIEF.md
# Banked Memory Window Mapper

This block translates a 16-bit CPU address into a physical memory address for a system with 128 KB of RAM, in eight 16 KB pages, and a ROM that holds several 16 KB pages. The region at 0x4000 and the region at 0x8000 are switchable 16 KB windows. All other regions are fixed. For each CPU address the block reports four things: the region kind (RAM, ROM, I/O or empty), the physical address, the RAM byte enables for a write, and a write-protect flag. The memories themselves are outside the block.

The CPU changes the mapping by writing to the system control port with bit 11 set in the written word. A write to that port with bit 11 clear is not a bank change: the block passes it on as a strobe for the ordinary peripheral functions. A static input tells the block whether a disk interface is fitted. That input decides whether the top of the space holds an extra ROM page and a 512-byte I/O area, or empty space and a 256-byte I/O area.

Top module: `bank_mapper`

## Requirements
- R1: A strobe on `sys_wr` changes the bank mapping in the following cycle only if `sys_wdata[11]` is 1. If that bit is 0, `periph_wr` is 1 in the same cycle and the mapping stays unchanged.
- R2: A bank write loads `sys_wdata[14:12]` as the RAM page shown at 0x4000–0x7FFF.
- R3: In a bank write, if any of data bits 4, 3, 1 or 0 is set, the 0x8000–0xBFFF window shows ROM page 3, 2, 1 or 0 respectively. The highest set bit of those four wins.
- R4: In a bank write where none of bits 4, 3, 1 and 0 is set, `sys_wdata[10:8]` selects the RAM page shown at 0x8000–0xBFFF.
- R5: 0x0000–0x3FFF is always RAM page 6. 0xC000–0xDFFF is always ROM page 4, an 8 KB page whose physical offset bit 13 is 0.
- R6: With `disk_fitted`=1, 0xE000–0xFDFF is ROM page 5 (offset bit 13 forced to 0) and 0xFE00–0xFFFF is I/O.
- R7: With `disk_fitted`=0, 0xE000–0xFEFF is empty and 0xFF00–0xFFFF is I/O.
- R8: After reset, the 0x8000 window shows ROM page 0 and the 0x4000 window shows RAM page 0.
- R9: The physical address always points at the even byte of a word: `phys_addr[0]` is 0. The address is formed as {page[2:0], offset[13:1], 0}.
- R10: A CPU write to a ROM or empty region sets `wprot` and leaves `ram_be` at 0. `wprot` is 0 at all other times.
- R11: A CPU write to RAM drives `ram_be` from `cpu_be`, where bit 0 enables the even byte and bit 1 the odd byte. For any read, or for a write outside RAM, `ram_be` is 0.
- R12: `region` is coded 0 for RAM, 1 for ROM, 2 for I/O and 3 for empty space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_wr | input | 1 | Write strobe to the system control port |
| sys_wdata | input | 16 | Word written to the system control port |
| disk_fitted | input | 1 | Disk interface present (static) |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wr | input | 1 | CPU access is a write |
| cpu_be | input | 2 | CPU byte enables (bit 0 even, bit 1 odd) |
| periph_wr | output | 1 | Port write forwarded to the peripheral functions |
| region | output | 2 | Region kind: 0 RAM, 1 ROM, 2 I/O, 3 empty |
| phys_addr | output | 17 | Physical RAM or ROM byte address, even |
| ram_be | output | 2 | RAM byte write enables |
| wprot | output | 1 | Write to a protected region |

## Verification
The bench builds the block with its default parameters: a 3-bit page number, RAM page 6 at the bottom of the space, and ROM pages 4 and 5 at the top. With these values every RAM page, all four switchable ROM pages and both layouts of the top region can be reached. Random bank words exercise the priority among the four ROM bits and the fallback to a RAM page. Toggling `disk_fitted` moves the boundaries at 0xFE00 and 0xFF00, and the bench checks both sides of each boundary.

// File: rtl/bank_mapper.sv
module bank_mapper #(
  parameter int PAGE_W       = 3,
  parameter int OFS_W        = 14,
  parameter int FIXED_RAM_PG = 6,
  parameter int SYS_ROM_PG   = 4,
  parameter int DISK_ROM_PG  = 5,
  parameter int CTRL_BIT     = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sys_wr,
  input  logic [15:0]             sys_wdata,
  input  logic                    disk_fitted,
  input  logic [15:0]             cpu_addr,
  input  logic                    cpu_wr,
  input  logic [1:0]              cpu_be,
  output logic                    periph_wr,
  output logic [1:0]              region,
  output logic [PAGE_W+OFS_W-1:0] phys_addr,
  output logic [1:0]              ram_be,
  output logic                    wprot
);
  localparam logic [1:0] RG_RAM = 2'd0, RG_ROM = 2'd1, RG_IO = 2'd2, RG_NONE = 2'd3;

  logic [PAGE_W-1:0] lo_pg, hi_pg, nxt_rom_pg, pg;
  logic              hi_rom, bank_wr, rom_hit;

  assign bank_wr   = sys_wr &  sys_wdata[CTRL_BIT];
  assign periph_wr = sys_wr & ~sys_wdata[CTRL_BIT];
  assign rom_hit   = sys_wdata[4] | sys_wdata[3] | sys_wdata[1] | sys_wdata[0];

  always_comb begin
    if (sys_wdata[4])      nxt_rom_pg = PAGE_W'(3);
    else if (sys_wdata[3]) nxt_rom_pg = PAGE_W'(2);
    else if (sys_wdata[1]) nxt_rom_pg = PAGE_W'(1);
    else                   nxt_rom_pg = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_pg  <= '0;
      hi_pg  <= '0;
      hi_rom <= 1'b1;
    end else if (bank_wr) begin
      lo_pg  <= PAGE_W'(sys_wdata[14:12]);
      hi_rom <= rom_hit;
      hi_pg  <= rom_hit ? nxt_rom_pg : PAGE_W'(sys_wdata[10:8]);
    end
  end

  always_comb begin
    region = RG_RAM;
    pg     = '0;
    unique case (cpu_addr[15:14])
      2'b00: pg = PAGE_W'(FIXED_RAM_PG);
      2'b01: pg = lo_pg;
      2'b10: begin
        region = hi_rom ? RG_ROM : RG_RAM;
        pg     = hi_pg;
      end
      default: begin
        if (!cpu_addr[13]) begin
          region = RG_ROM;
          pg     = PAGE_W'(SYS_ROM_PG);
        end else if (cpu_addr[12:8] == 5'h1F) begin
          region = RG_IO;
        end else if (disk_fitted) begin
          if (cpu_addr[12:9] == 4'hF) region = RG_IO;
          else begin
            region = RG_ROM;
            pg     = PAGE_W'(DISK_ROM_PG);
          end
        end else begin
          region = RG_NONE;
        end
      end
    endcase
  end

  assign phys_addr = {pg, cpu_addr[13] & ~(cpu_addr[15] & cpu_addr[14]),
                      cpu_addr[OFS_W-2:1], 1'b0};
  assign ram_be    = (cpu_wr && region == RG_RAM) ? cpu_be : 2'b00;
  assign wprot     = cpu_wr && (region == RG_ROM || region == RG_NONE);
endmodule

module bank_mapper_chk #(
  parameter int PAGE_W       = 3,
  parameter int PA_W         = 17,
  parameter int FIXED_RAM_PG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sys_wr,
  input logic [15:0]       sys_wdata,
  input logic [15:0]       cpu_addr,
  input logic [1:0]        region,
  input logic [PA_W-1:0]   phys_addr,
  input logic [1:0]        ram_be,
  input logic              wprot,
  input logic [PAGE_W-1:0] lo_pg,
  input logic [PAGE_W-1:0] hi_pg,
  input logic              hi_rom
);
  assert_keep_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_wr && !sys_wdata[11]) |=> ($stable(lo_pg) && $stable(hi_pg) && $stable(hi_rom)));

  assert_rom_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_wr && sys_wdata[11] && sys_wdata[4]) |=> (hi_rom && hi_pg == PAGE_W'(3)));

  assert_low_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00) |-> (region == 2'd0 && phys_addr[PA_W-1:PA_W-PAGE_W] == PAGE_W'(FIXED_RAM_PG)));

  assert_reset_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (hi_rom && hi_pg == '0 && lo_pg == '0));

  assert_even_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[0] == 1'b0);

  assert_protect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wprot |-> (ram_be == 2'b00 && (region == 2'd1 || region == 2'd3)));
endmodule

bind bank_mapper bank_mapper_chk #(.PAGE_W(PAGE_W), .PA_W(PAGE_W+OFS_W), .FIXED_RAM_PG(FIXED_RAM_PG)) u_chk (
  .clk(clk), .rst_n(rst_n), .sys_wr(sys_wr), .sys_wdata(sys_wdata), .cpu_addr(cpu_addr),
  .region(region), .phys_addr(phys_addr), .ram_be(ram_be), .wprot(wprot),
  .lo_pg(lo_pg), .hi_pg(hi_pg), .hi_rom(hi_rom));

// File: tb/tb_bank_mapper.sv
module tb_bank_mapper;
  logic        clk = 0, rst_n = 0, sys_wr = 0, disk_fitted = 0, cpu_wr = 0;
  logic [15:0] sys_wdata = '0, cpu_addr = '0;
  logic [1:0]  cpu_be = '0;
  logic        periph_wr, wprot;
  logic [1:0]  region, ram_be;
  logic [16:0] phys_addr;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] m_lo = 0, m_hi = 0;
  logic       m_rom = 1;

  bank_mapper dut (.*);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_bank(logic [15:0] d);
    if (!d[11]) return;
    m_lo  = d[14:12];
    m_rom = d[4] | d[3] | d[1] | d[0];
    m_hi  = d[4] ? 3'd3 : d[3] ? 3'd2 : d[1] ? 3'd1 : d[0] ? 3'd0 : d[10:8];
  endtask

  task automatic port_write(logic [15:0] d);
    @(negedge clk);
    sys_wr = 1; sys_wdata = d;
    #1 chk("R1 periph_wr", periph_wr, !d[11]);
    @(negedge clk);
    sys_wr = 0;
    model_bank(d);
  endtask

  task automatic access(string req, logic [15:0] a, logic w, logic [1:0] be, logic dk);
    logic [1:0] er; logic [2:0] pg; logic b13;
    @(negedge clk);
    cpu_addr = a; cpu_wr = w; cpu_be = be; disk_fitted = dk;
    pg = 0; b13 = a[13];
    if (a < 16'h4000)      begin er = 0; pg = 6; end
    else if (a < 16'h8000) begin er = 0; pg = m_lo; end
    else if (a < 16'hC000) begin er = m_rom ? 2'd1 : 2'd0; pg = m_hi; end
    else if (a < 16'hE000) begin er = 1; pg = 4; b13 = 0; end
    else if (a >= 16'hFF00) er = 2;
    else if (dk && a >= 16'hFE00) er = 2;
    else if (dk) begin er = 1; pg = 5; b13 = 0; end
    else er = 3;
    #1;
    chk({req, " region R12"}, region, er);
    if (er < 2) chk({req, " phys R9"}, phys_addr, {pg, b13, a[12:1], 1'b0});
    chk({req, " ram_be R11"}, ram_be, (w && er == 0) ? be : 2'b00);
    chk({req, " wprot R10"}, wprot, w && (er == 1 || er == 3));
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1;
    access("R8 reset hi", 16'h8000, 0, 2'b00, 0);
    access("R8 reset lo", 16'h4002, 0, 2'b00, 0);
    port_write(16'h5A00 | 16'h0800);
    access("R2 lo page5", 16'h4124, 1, 2'b11, 0);
    access("R4 hi ram2", 16'h8001, 1, 2'b01, 0);
    port_write(16'h081B);
    access("R3 all rom bits", 16'hBFFE, 1, 2'b10, 0);
    port_write(16'h0803);
    access("R3 bits1,0", 16'h9000, 0, 2'b00, 0);
    port_write(16'h0809);
    access("R3 bits3,0", 16'hA000, 0, 2'b00, 0);
    port_write(16'h7713);
    access("R1 ignored hi", 16'h8000, 0, 2'b00, 0);
    access("R1 ignored lo", 16'h7FFE, 1, 2'b01, 0);
    access("R5 low", 16'h3FFF, 1, 2'b11, 1);
    access("R5 sysrom", 16'hDFFE, 1, 2'b11, 1);
    access("R6 diskrom", 16'hE000, 1, 2'b01, 1);
    access("R6 diskrom top", 16'hFDFE, 0, 2'b00, 1);
    access("R6 io", 16'hFE00, 1, 2'b11, 1);
    access("R7 empty", 16'hE000, 1, 2'b11, 0);
    access("R7 empty top", 16'hFEFE, 1, 2'b11, 0);
    access("R7 io", 16'hFF00, 1, 2'b11, 0);
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) port_write(16'($urandom()));
      access("random", 16'($urandom()), 1'($urandom()), 2'($urandom()), 1'($urandom()));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule